// File: doc/BRIEF.md
# Multichannel DMA Register Front End

This block is the register-access side of a DMA controller with up to eight write-direction channels and eight read-direction channels. It decodes a simple word-addressed register bus into one register file per channel, plus a bank of engine-level controls for each direction: an engine enable, a doorbell that starts a channel, and interrupt status, mask and clear registers. The datapath that moves the data sits outside the block. It receives the channel registers on wide flattened outputs and the start pulses. It reports completion and abort events back through per-channel input pulses.

Channel registers can be reached in one of two ways, chosen by the `UNROLL` parameter. In viewport mode (`UNROLL=0`), a selector register picks one direction and one channel, and a single window at 0x100 maps that channel's nine registers. In unrolled mode (`UNROLL=1`), every channel has a fixed block of its own. Write channel n is at 0x200 + n·0x200 and read channel n is at 0x300 + n·0x200, so all channels can be reached at any time without a selector. Both modes reach the same per-channel storage.

Top module: `dma_regmap`

## Requirements
- R1: After reset every register reads 0, no start pulse is active and both interrupt outputs are low.
- R2: In viewport mode the selector is at 0x040. Bit 31 selects the direction (1 read, 0 write) and bits 2:0 select the channel. It reads back as {dir, 28'b0, channel}. Accesses to 0x100–0x120 reach the selected channel's registers.
- R3: In viewport mode, when the selector names a channel number at or above that direction's channel count, window reads return 0 and window writes change no register.
- R4: In unrolled mode, write channel n's block is at 0x200 + n·0x200 and read channel n's block is at 0x300 + n·0x200. The selector at 0x040 is absent: it reads 0 and writes have no effect.
- R5: Inside a channel block, the word offsets are 0x00 control 1, 0x04 control 2, 0x08 transfer size, 0x0C/0x10 source low/high, 0x14/0x18 destination low/high and 0x1C/0x20 list pointer low/high. Offsets 0x24–0xFC and addresses that are not word aligned read 0 and are not written.
- R6: The engine bank addresses are: write enable 0x00, write doorbell 0x04, write status 0x08, write mask 0x0C, write clear 0x10; read enable 0x20, read doorbell 0x24, read status 0x28, read mask 0x2C, read clear 0x30. The enable is bit 0. Doorbell and clear read 0.
- R7: Writing a channel number in bits 2:0 to a doorbell raises that direction's start output for that channel for exactly one cycle, starting at the clock edge that takes the write. This happens only when that direction's enable is 1 and the channel exists; otherwise no start pulse occurs.
- R8: A done pulse on channel n sets status bit n and an abort pulse sets status bit 16+n. Status bits hold until a 1 is written to the same bit of the clear register. A set and a clear of the same bit in the same cycle leave the bit set.
- R9: A direction's interrupt output is high when any status bit is 1 while the mask bit at the same position is 0.
- R10: The write and read directions have separate storage: an access to one direction never changes the other direction's channel registers, status or start outputs.
- R11: Each channel register written over the bus appears on the flattened channel output at bit offset ((channel·9 + register index)·32) from the clock edge that takes the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe, taken at the clock edge |
| bus_rd_en | input | 1 | Register read strobe; read data is combinational |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data; 0 when no read or unmapped |
| wr_done_i | input | NUM_WR_CH | Write-channel done event pulses |
| wr_abort_i | input | NUM_WR_CH | Write-channel abort event pulses |
| rd_done_i | input | NUM_RD_CH | Read-channel done event pulses |
| rd_abort_i | input | NUM_RD_CH | Read-channel abort event pulses |
| wr_start_o | output | NUM_WR_CH | One-cycle start pulse per write channel |
| rd_start_o | output | NUM_RD_CH | One-cycle start pulse per read channel |
| wr_irq_o | output | 1 | Write-direction interrupt |
| rd_irq_o | output | 1 | Read-direction interrupt |
| wr_chan_regs_o | output | NUM_WR_CH·9·32 | All write-channel registers, flattened |
| rd_chan_regs_o | output | NUM_RD_CH·9·32 | All read-channel registers, flattened |

## Verification
The case that needs care is a software write to a clear register that lands in the same cycle as a done or abort pulse for the same status bit. The bench sets up this case by raising the abort input on the same falling edge that drives the clear write, so both reach the block at one clock edge. It then reads the status register back and expects the bit to remain set, with the interrupt still following the mask. A second pairing starts a doorbell while a status bit on the same direction is pending, to show that the start pulse and the status are independent.

// File: rtl/dma_regmap_pkg.sv
package dma_regmap_pkg;
    localparam int REG_W   = 32;
    localparam int CH_REGS = 9;
    localparam int IDX_W   = 4;

    // engine bank offsets (page 0)
    localparam logic [7:0] OFS_WR_EN   = 8'h00;
    localparam logic [7:0] OFS_WR_DB   = 8'h04;
    localparam logic [7:0] OFS_WR_STAT = 8'h08;
    localparam logic [7:0] OFS_WR_MASK = 8'h0C;
    localparam logic [7:0] OFS_WR_CLR  = 8'h10;
    localparam logic [7:0] OFS_RD_EN   = 8'h20;
    localparam logic [7:0] OFS_RD_DB   = 8'h24;
    localparam logic [7:0] OFS_RD_STAT = 8'h28;
    localparam logic [7:0] OFS_RD_MASK = 8'h2C;
    localparam logic [7:0] OFS_RD_CLR  = 8'h30;
    localparam logic [7:0] OFS_VIEW    = 8'h40;

    localparam int ABORT_LSB = 16;

    typedef enum logic {DIR_WR = 1'b0, DIR_RD = 1'b1} dir_e;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_regmap_pkg::*;
#(
    parameter int NREG = CH_REGS,
    parameter int W    = REG_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     idx,
    input  logic [W-1:0]         wdata,
    output logic [NREG*W-1:0]    regs_o
);
    typedef struct packed {
        logic [NREG-1:0][W-1:0] r;
    } chan_st_t;

    chan_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < NREG; i++) begin
            if (wr_en && (int'(idx) == i)) s_d.r[i] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign regs_o = s_q.r;

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_o));
endmodule

// File: rtl/dma_dir_ctrl.sv
module dma_dir_ctrl
    import dma_regmap_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_we,
    input  logic             db_we,
    input  logic             mask_we,
    input  logic             clr_we,
    input  logic [REG_W-1:0] wdata,
    input  logic [NCH-1:0]   done_i,
    input  logic [NCH-1:0]   abort_i,
    output logic [NCH-1:0]   start_o,
    output logic             en_o,
    output logic [REG_W-1:0] stat_o,
    output logic [REG_W-1:0] mask_o,
    output logic             irq_o
);
    typedef struct packed {
        logic           en;
        logic [NCH-1:0] done;
        logic [NCH-1:0] abort;
        logic [NCH-1:0] mdone;
        logic [NCH-1:0] mabort;
        logic [NCH-1:0] start;
    } dir_st_t;

    dir_st_t s_d, s_q;
    logic    unused_wdata;

    assign unused_wdata = ^wdata;

    always_comb begin
        s_d       = s_q;
        s_d.start = '0;
        if (en_we) s_d.en = wdata[0];
        if (mask_we) begin
            s_d.mdone  = wdata[NCH-1:0];
            s_d.mabort = wdata[ABORT_LSB +: NCH];
        end
        for (int c = 0; c < NCH; c++) begin
            if (db_we && s_q.en && (int'(wdata[2:0]) == c)) s_d.start[c] = 1'b1;
        end
        if (clr_we) begin
            s_d.done  = s_d.done  & ~wdata[NCH-1:0];
            s_d.abort = s_d.abort & ~wdata[ABORT_LSB +: NCH];
        end
        s_d.done  = s_d.done  | done_i;
        s_d.abort = s_d.abort | abort_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        stat_o = '0;
        mask_o = '0;
        stat_o[NCH-1:0]            = s_q.done;
        stat_o[ABORT_LSB +: NCH]   = s_q.abort;
        mask_o[NCH-1:0]            = s_q.mdone;
        mask_o[ABORT_LSB +: NCH]   = s_q.mabort;
    end

    assign start_o = s_q.start;
    assign en_o    = s_q.en;
    assign irq_o   = |(s_q.done & ~s_q.mdone) | |(s_q.abort & ~s_q.mabort);

    // R7
    start_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(start_o));
    // R7
    start_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|start_o) |-> (en_o && $past(db_we)));
    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|done_i) |=> ((stat_o[NCH-1:0] & $past(done_i)) == $past(done_i)));
    // R9
    irq_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_o != '0) && (mask_o == '0)) |-> irq_o);
endmodule

// File: rtl/dma_regmap.sv
module dma_regmap
    import dma_regmap_pkg::*;
#(
    parameter int NUM_WR_CH = 8,
    parameter int NUM_RD_CH = 8,
    parameter bit UNROLL    = 1'b0,
    parameter int ADDR_W    = 13
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               bus_wr_en,
    input  logic                               bus_rd_en,
    input  logic [ADDR_W-1:0]                  bus_addr,
    input  logic [REG_W-1:0]                   bus_wdata,
    output logic [REG_W-1:0]                   bus_rdata,
    input  logic [NUM_WR_CH-1:0]               wr_done_i,
    input  logic [NUM_WR_CH-1:0]               wr_abort_i,
    input  logic [NUM_RD_CH-1:0]               rd_done_i,
    input  logic [NUM_RD_CH-1:0]               rd_abort_i,
    output logic [NUM_WR_CH-1:0]               wr_start_o,
    output logic [NUM_RD_CH-1:0]               rd_start_o,
    output logic                               wr_irq_o,
    output logic                               rd_irq_o,
    output logic [NUM_WR_CH*CH_REGS*REG_W-1:0] wr_chan_regs_o,
    output logic [NUM_RD_CH*CH_REGS*REG_W-1:0] rd_chan_regs_o
);
    localparam int PAGE_W = ADDR_W - 8;
    localparam int BLK_W  = CH_REGS * REG_W;

    typedef struct packed {
        logic       vdir;
        logic [2:0] vch;
    } top_st_t;

    top_st_t s_d, s_q;

    logic [PAGE_W-1:0] page;
    logic [7:0]        lo;
    logic              glob, idx_ok, tgt_hit, tgt_dir, ch_ok, chan_sel;
    int                idx, tgt_ch;
    logic              g_wr;
    logic              wr_en_q, rd_en_q;
    logic [REG_W-1:0]  wr_stat, wr_mask, rd_stat, rd_mask;

    // address decode
    always_comb begin
        page    = bus_addr[ADDR_W-1:8];
        lo      = bus_addr[7:0];
        glob    = (page == '0);
        idx     = int'(lo[7:2]);
        idx_ok  = (idx < CH_REGS) && (lo[1:0] == 2'b00);
        tgt_hit = 1'b0;
        tgt_dir = DIR_WR;
        tgt_ch  = 0;
        if (UNROLL) begin
            if (bus_addr[ADDR_W-1:9] != '0) begin
                tgt_hit = 1'b1;
                tgt_dir = bus_addr[8];
                tgt_ch  = int'(bus_addr[ADDR_W-1:9]) - 1;
            end
        end else begin
            tgt_hit = (page == PAGE_W'(1));
            tgt_dir = s_q.vdir;
            tgt_ch  = int'(s_q.vch);
        end
        ch_ok    = tgt_dir ? (tgt_ch < NUM_RD_CH) : (tgt_ch < NUM_WR_CH);
        chan_sel = tgt_hit && ch_ok && idx_ok;
        g_wr     = bus_wr_en && glob;
    end

    // viewport selector
    always_comb begin
        s_d = s_q;
        if (!UNROLL && g_wr && (lo == OFS_VIEW)) begin
            s_d.vdir = bus_wdata[31];
            s_d.vch  = bus_wdata[2:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // per-channel register files
    for (genvar g = 0; g < NUM_WR_CH; g++) begin : g_wr_ch
        dma_chan_regs u_regs (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (bus_wr_en && chan_sel && (tgt_dir == DIR_WR) && (tgt_ch == g)),
            .idx    (lo[5:2]),
            .wdata  (bus_wdata),
            .regs_o (wr_chan_regs_o[g*BLK_W +: BLK_W])
        );
    end
    for (genvar g = 0; g < NUM_RD_CH; g++) begin : g_rd_ch
        dma_chan_regs u_regs (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (bus_wr_en && chan_sel && (tgt_dir == DIR_RD) && (tgt_ch == g)),
            .idx    (lo[5:2]),
            .wdata  (bus_wdata),
            .regs_o (rd_chan_regs_o[g*BLK_W +: BLK_W])
        );
    end

    // engine banks
    dma_dir_ctrl #(.NCH(NUM_WR_CH)) u_wr_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_we   (g_wr && (lo == OFS_WR_EN)),
        .db_we   (g_wr && (lo == OFS_WR_DB)),
        .mask_we (g_wr && (lo == OFS_WR_MASK)),
        .clr_we  (g_wr && (lo == OFS_WR_CLR)),
        .wdata   (bus_wdata),
        .done_i  (wr_done_i),
        .abort_i (wr_abort_i),
        .start_o (wr_start_o),
        .en_o    (wr_en_q),
        .stat_o  (wr_stat),
        .mask_o  (wr_mask),
        .irq_o   (wr_irq_o)
    );

    dma_dir_ctrl #(.NCH(NUM_RD_CH)) u_rd_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_we   (g_wr && (lo == OFS_RD_EN)),
        .db_we   (g_wr && (lo == OFS_RD_DB)),
        .mask_we (g_wr && (lo == OFS_RD_MASK)),
        .clr_we  (g_wr && (lo == OFS_RD_CLR)),
        .wdata   (bus_wdata),
        .done_i  (rd_done_i),
        .abort_i (rd_abort_i),
        .start_o (rd_start_o),
        .en_o    (rd_en_q),
        .stat_o  (rd_stat),
        .mask_o  (rd_mask),
        .irq_o   (rd_irq_o)
    );

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_rd_en) begin
            if (glob) begin
                case (lo)
                    OFS_WR_EN:   bus_rdata = {31'b0, wr_en_q};
                    OFS_WR_STAT: bus_rdata = wr_stat;
                    OFS_WR_MASK: bus_rdata = wr_mask;
                    OFS_RD_EN:   bus_rdata = {31'b0, rd_en_q};
                    OFS_RD_STAT: bus_rdata = rd_stat;
                    OFS_RD_MASK: bus_rdata = rd_mask;
                    OFS_VIEW:    bus_rdata = UNROLL ? '0 : {s_q.vdir, 28'b0, s_q.vch};
                    default:     bus_rdata = '0;
                endcase
            end else if (chan_sel) begin
                if (tgt_dir == DIR_RD)
                    bus_rdata = rd_chan_regs_o[(tgt_ch*CH_REGS + idx)*REG_W +: REG_W];
                else
                    bus_rdata = wr_chan_regs_o[(tgt_ch*CH_REGS + idx)*REG_W +: REG_W];
            end
        end
    end

    // R10
    dir_isolate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && chan_sel && (tgt_dir == DIR_WR)) |=> $stable(rd_chan_regs_o));
    // R3
    dead_chan_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && !glob && tgt_hit && !ch_ok) |-> (bus_rdata == '0));
endmodule

// File: tb/dma_regmap_bench.sv
`timescale 1ns/1ps
module dma_regmap_bench;
    localparam int BLK = 9 * 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        vw_wr = 0, vw_rd = 0, un_wr = 0, un_rd = 0;
    logic [12:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] vw_rdata, un_rdata;
    logic [7:0]  vw_wdone = '0, vw_wabort = '0;
    logic [5:0]  vw_rdone = '0, vw_rabort = '0;
    logic [7:0]  vw_wstart, un_wstart;
    logic [5:0]  vw_rstart;
    logic [7:0]  un_rstart;
    logic        vw_wirq, vw_rirq, un_wirq, un_rirq;
    logic [8*BLK-1:0] vw_wregs, un_wregs, un_rregs;
    logic [6*BLK-1:0] vw_rregs;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    dma_regmap #(.NUM_WR_CH(8), .NUM_RD_CH(6), .UNROLL(1'b0)) u_dma_regmap (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(vw_wr), .bus_rd_en(vw_rd),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(vw_rdata),
        .wr_done_i(vw_wdone), .wr_abort_i(vw_wabort),
        .rd_done_i(vw_rdone), .rd_abort_i(vw_rabort),
        .wr_start_o(vw_wstart), .rd_start_o(vw_rstart),
        .wr_irq_o(vw_wirq), .rd_irq_o(vw_rirq),
        .wr_chan_regs_o(vw_wregs), .rd_chan_regs_o(vw_rregs));

    dma_regmap #(.NUM_WR_CH(8), .NUM_RD_CH(8), .UNROLL(1'b1)) u_dma_regmap_unroll (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(un_wr), .bus_rd_en(un_rd),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(un_rdata),
        .wr_done_i(8'h0), .wr_abort_i(8'h0),
        .rd_done_i(8'h0), .rd_abort_i(8'h0),
        .wr_start_o(un_wstart), .rd_start_o(un_rstart),
        .wr_irq_o(un_wirq), .rd_irq_o(un_rirq),
        .wr_chan_regs_o(un_wregs), .rd_chan_regs_o(un_rregs));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input bit unr, input logic [12:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d;
        if (unr) un_wr = 1; else vw_wr = 1;
        @(negedge clk);
        un_wr = 0; vw_wr = 0;
    endtask

    task automatic rd(input bit unr, input logic [12:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        if (unr) un_rd = 1; else vw_rd = 1;
        #1;
        d = unr ? un_rdata : vw_rdata;
        un_rd = 0; vw_rd = 0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(0, 13'h008, d); check("R1 wr status", d, 0);
        rd(0, 13'h000, d); check("R1 wr enable", d, 0);
        rd(0, 13'h040, d); check("R1 viewport", d, 0);
        rd(0, 13'h108, d); check("R1 window", d, 0);
        check("R1 irq", {30'b0, vw_wirq, vw_rirq}, 0);
        check("R1 start", {vw_wstart, vw_rstart}, 0);
    endtask

    task automatic t_viewport();
        logic [31:0] d;
        wr(0, 13'h040, 32'h0000_0003);
        wr(0, 13'h108, 32'h0000_1234);
        rd(0, 13'h108, d); check("R2 wr ch3 size", d, 32'h1234);
        check("R11 wr ch3 size out", vw_wregs[(3*9+2)*32 +: 32], 32'h1234);
        wr(0, 13'h040, 32'h8000_0003);
        rd(0, 13'h040, d); check("R2 viewport readback", d, 32'h8000_0003);
        rd(0, 13'h108, d); check("R10 rd ch3 separate", d, 0);
        wr(0, 13'h108, 32'h0000_BEEF);
        wr(0, 13'h040, 32'h0000_0003);
        rd(0, 13'h108, d); check("R10 wr ch3 kept", d, 32'h1234);
        check("R11 rd ch3 size out", vw_rregs[(3*9+2)*32 +: 32], 32'hBEEF);
        wr(0, 13'h120, 32'hA5A5_0001);
        rd(0, 13'h120, d); check("R5 llp high", d, 32'hA5A5_0001);
        check("R5 llp high out", vw_wregs[(3*9+8)*32 +: 32], 32'hA5A5_0001);
        wr(0, 13'h124, 32'hFFFF_FFFF);
        rd(0, 13'h124, d); check("R5 hole", d, 0);
        rd(0, 13'h109, d); check("R5 misaligned", d, 0);
        check("R5 hole no write", vw_wregs[(3*9+0)*32 +: 32], 0);
    endtask

    task automatic t_dead_channel();
        logic [31:0] d;
        wr(0, 13'h040, 32'h8000_0006);
        wr(0, 13'h100, 32'h0000_0055);
        rd(0, 13'h100, d); check("R3 missing rd ch6 read", d, 0);
        wr(0, 13'h040, 32'h8000_0005);
        rd(0, 13'h100, d); check("R3 rd ch5 untouched", d, 0);
        check("R3 rd ch0 untouched", vw_rregs[31:0], 0);
    endtask

    task automatic t_unrolled();
        logic [31:0] d;
        wr(1, 13'h0C0C, 32'h1111_2222);
        wr(1, 13'h0D0C, 32'h3333_4444);
        wr(1, 13'h1120, 32'h5555_6666);
        rd(1, 13'h0C0C, d); check("R4 wr ch5 src", d, 32'h1111_2222);
        rd(1, 13'h0D0C, d); check("R4 rd ch5 src", d, 32'h3333_4444);
        rd(1, 13'h1120, d); check("R4 rd ch7 llp hi", d, 32'h5555_6666);
        check("R11 unroll wr ch5 out", un_wregs[(5*9+3)*32 +: 32], 32'h1111_2222);
        check("R11 unroll rd ch7 out", un_rregs[(7*9+8)*32 +: 32], 32'h5555_6666);
        wr(1, 13'h040, 32'h8000_0001);
        rd(1, 13'h040, d); check("R4 no viewport", d, 0);
        rd(1, 13'h0308, d); check("R4 rd ch0 size", d, 0);
    endtask

    task automatic t_doorbell();
        logic [31:0] d;
        wr(0, 13'h004, 32'h2);
        check("R7 disabled no start", {24'b0, vw_wstart}, 0);
        wr(0, 13'h000, 32'h1);
        rd(0, 13'h000, d); check("R6 wr enable", d, 1);
        wr(0, 13'h004, 32'h2);
        check("R7 wr ch2 start", {24'b0, vw_wstart}, 32'h4);
        check("R10 no rd start", {26'b0, vw_rstart}, 0);
        @(negedge clk);
        check("R7 one cycle", {24'b0, vw_wstart}, 0);
        rd(0, 13'h004, d); check("R6 doorbell reads 0", d, 0);
        wr(0, 13'h020, 32'h1);
        wr(0, 13'h024, 32'h7);
        check("R7 missing channel", {26'b0, vw_rstart}, 0);
        wr(0, 13'h024, 32'h5);
        check("R7 rd ch5 start", {26'b0, vw_rstart}, 32'h20);
    endtask

    task automatic t_status();
        logic [31:0] d;
        @(negedge clk); vw_wdone = 8'h02; @(negedge clk); vw_wdone = 0;
        rd(0, 13'h008, d); check("R8 done bit", d, 32'h0000_0002);
        check("R9 irq on", {31'b0, vw_wirq}, 1);
        @(negedge clk); vw_wabort = 8'h10; @(negedge clk); vw_wabort = 0;
        rd(0, 13'h008, d); check("R8 abort bit", d, 32'h0010_0002);
        wr(0, 13'h00C, 32'h0010_0002);
        rd(0, 13'h00C, d); check("R6 mask readback", d, 32'h0010_0002);
        check("R9 masked", {31'b0, vw_wirq}, 0);
        wr(0, 13'h004, 32'h1);
        check("R7 start with pending status", {24'b0, vw_wstart}, 32'h2);
        wr(0, 13'h010, 32'h0000_0002);
        rd(0, 13'h008, d); check("R8 clear done", d, 32'h0010_0000);
        // clear and abort in the same cycle
        @(negedge clk);
        addr = 13'h010; wdata = 32'h0010_0000; vw_wr = 1; vw_wabort = 8'h10;
        @(negedge clk);
        vw_wr = 0; vw_wabort = 0;
        rd(0, 13'h008, d); check("R8 set wins", d, 32'h0010_0000);
        wr(0, 13'h00C, 32'h0);
        check("R9 unmasked", {31'b0, vw_wirq}, 1);
        wr(0, 13'h010, 32'h0010_0000);
        rd(0, 13'h008, d); check("R8 cleared", d, 0);
        check("R9 irq off", {31'b0, vw_wirq}, 0);
        rd(0, 13'h028, d); check("R10 rd status clean", d, 0);
        @(negedge clk); vw_rdone = 6'h01; @(negedge clk); vw_rdone = 0;
        rd(0, 13'h028, d); check("R8 rd done", d, 1);
        check("R9 rd irq", {30'b0, vw_rirq, vw_wirq}, 32'h2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_viewport();
        t_dead_channel();
        t_unrolled();
        t_doorbell();
        t_status();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule